// File: doc/BRIEF.md
# Virtual Supervisor Interrupt-Pending Composer

This block merges every source of virtual supervisor interrupts that a hypervisor controls into the three pending bits a guest supervisor sees. The external pending bit can come from three places: the hypervisor's injected bit, one entry of the guest-external pending vector picked by a selector field, or the platform's external line for the guest. The timer pending bit comes from the hypervisor's injected bit or from a compare. That compare shifts the running time counter by a per-guest delta and tests the result against the guest's timer compare value. The guest-external summary bit is high when any guest-external source is both pending and enabled.

All three outputs are registered and reset to zero. A combinational flag reports a selector value that names no implemented guest-external entry. Such a value adds nothing to the external pending bit. The surrounding register file owns the selector, the vectors and the time values, and it reads the three outputs back.

Top module: `vsip_compose`

## Requirements
- R1: `vs_seip` is the OR of `inj_seip`, `plat_seip` and the selected guest-external bit, which is `ge_pend[ge_sel]` when 1 <= `ge_sel` <= GEILEN.
- R2: `vs_stip` is `inj_stip` ORed with the unsigned test (`time_now` + `time_delta`, wrapped modulo 2^64) >= `time_cmp`. Equality counts as pending.
- R3: `sg_eip` is the OR over bits 1..GEILEN of `ge_pend & ge_en`.
- R4: Bit 0 of `ge_pend` and bit 0 of `ge_en` have no effect on any output.
- R5: A `ge_sel` value of 0 adds no guest-external term to `vs_seip`.
- R6: `sel_illegal` is high in the same cycle as any `ge_sel` value greater than GEILEN. Such a value adds no guest-external term to `vs_seip`.
- R7: An input change appears on `vs_seip`, `vs_stip` and `sg_eip` at the first rising clock edge after the change, and not before that edge.
- R8: While `rst_n` is low at a rising edge, all three pending outputs become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inj_seip | input | 1 | Hypervisor-injected external pending |
| inj_stip | input | 1 | Hypervisor-injected timer pending |
| plat_seip | input | 1 | Platform external interrupt line for the guest |
| ge_pend | input | GEILEN+1 | Guest-external pending vector, bit 0 unused |
| ge_en | input | GEILEN+1 | Guest-external enable vector, bit 0 unused |
| ge_sel | input | 6 | Guest-external selector |
| time_now | input | 64 | Running time counter |
| time_delta | input | 64 | Per-guest time offset |
| time_cmp | input | 64 | Guest timer compare value |
| vs_seip | output | 1 | Composed external pending |
| vs_stip | output | 1 | Composed timer pending |
| sg_eip | output | 1 | Guest-external summary pending |
| sel_illegal | output | 1 | Selector exceeds GEILEN |

## Verification
Each external source is driven alone so that a failure points at the missing term. The selector is then swept over 0, an in-range middle value, GEILEN and GEILEN+1, both with and without the addressed pending bit set. This exposes off-by-one errors in the range check. The timer is tested at equality, one below equality, across the 64-bit wrap of the sum and across the sign boundary, which separates an unsigned compare from a signed one. The enable mask is tested with a matching pair, with pending and enable set at different positions, and with only bit 0 set.

// File: rtl/vsip_pkg.sv
// Package: shared widths and the registered pending-bit bundle.
// Assumes: the selector width is fixed by the register layout.
package vsip_pkg;
    localparam int SEL_W  = 6;
    localparam int TIME_W = 64;

    typedef struct packed {
        logic seip;
        logic stip;
        logic sgeip;
    } vsip_bits_t;
endpackage

// File: rtl/vsip_guest_select.sv
// Module: picks one guest-external pending bit by selector and flags
// selector values above GEILEN. Entry 0 never matches.
// Assumes: 1 <= GEILEN <= 63; pend holds entries 1..GEILEN only.
module vsip_guest_select #(
    parameter int GEILEN = 8,
    parameter int SEL_W  = 6
) (
    input  logic [GEILEN:1]  pend,
    input  logic [SEL_W-1:0] sel,
    output logic             pick,
    output logic             illegal
);
    logic [GEILEN:1] hit;

    // One comparator per implemented entry; at most one can match.
    for (genvar g = 1; g <= GEILEN; g++) begin : g_hit
        assign hit[g] = pend[g] & (sel == SEL_W'(g));
    end

    // Range flag and merged pick.
    always_comb begin
        illegal = (sel > SEL_W'(GEILEN));
        pick    = |hit;
    end
endmodule

// File: rtl/vsip_timer_cmp.sv
// Module: shifted timer compare. Adds the offset to the time counter
// with modulo wrap and tests the sum unsigned against the compare value.
// Assumes: all three operands are the same width.
module vsip_timer_cmp #(
    parameter int TIME_W = 64
) (
    input  logic [TIME_W-1:0] now,
    input  logic [TIME_W-1:0] delta,
    input  logic [TIME_W-1:0] cmp,
    output logic              fire
);
    logic [TIME_W-1:0] shifted;

    // Wrapped sum followed by the unsigned greater-or-equal test.
    always_comb begin
        shifted = now + delta;
        fire    = (shifted >= cmp);
    end
endmodule

// File: rtl/vsip_guest_reduce.sv
// Module: summary of guest-external sources that are both pending and enabled.
// Assumes: the caller passes entries 1..GEILEN only.
module vsip_guest_reduce #(
    parameter int GEILEN = 8
) (
    input  logic [GEILEN:1] pend,
    input  logic [GEILEN:1] en,
    output logic            any
);
    // Masked OR reduction.
    always_comb any = |(pend & en);
endmodule

// File: rtl/vsip_compose.sv
// Module: top of the virtual supervisor pending composer. Merges the
// injected, platform, guest-external and timer sources into three
// registered pending bits.
// Assumes: synchronous active-low reset; 1 <= GEILEN <= 63.
module vsip_compose
    import vsip_pkg::*;
#(
    parameter int GEILEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inj_seip,
    input  logic              inj_stip,
    input  logic              plat_seip,
    input  logic [GEILEN:0]   ge_pend,
    input  logic [GEILEN:0]   ge_en,
    input  logic [SEL_W-1:0]  ge_sel,
    input  logic [TIME_W-1:0] time_now,
    input  logic [TIME_W-1:0] time_delta,
    input  logic [TIME_W-1:0] time_cmp,
    output logic              vs_seip,
    output logic              vs_stip,
    output logic              sg_eip,
    output logic              sel_illegal
);
    logic       sel_pick;
    logic       tmr_fire;
    logic       ge_any;
    logic       unused_bit0;
    vsip_bits_t nxt_q;
    vsip_bits_t cur_q;

    // Entry 0 of both vectors is read-only zero and is dropped here.
    assign unused_bit0 = ge_pend[0] ^ ge_en[0];

    vsip_guest_select #(.GEILEN(GEILEN), .SEL_W(SEL_W)) u_sel (
        .pend    (ge_pend[GEILEN:1]),
        .sel     (ge_sel),
        .pick    (sel_pick),
        .illegal (sel_illegal)
    );

    vsip_timer_cmp #(.TIME_W(TIME_W)) u_tmr (
        .now   (time_now),
        .delta (time_delta),
        .cmp   (time_cmp),
        .fire  (tmr_fire)
    );

    vsip_guest_reduce #(.GEILEN(GEILEN)) u_red (
        .pend (ge_pend[GEILEN:1]),
        .en   (ge_en[GEILEN:1]),
        .any  (ge_any)
    );

    // Next-state composition of the three pending bits.
    always_comb begin
        nxt_q.seip  = inj_seip | plat_seip | (sel_pick & ~sel_illegal);
        nxt_q.stip  = inj_stip | tmr_fire;
        nxt_q.sgeip = ge_any;
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_q;
    end

    assign vs_seip = cur_q.seip;
    assign vs_stip = cur_q.stip;
    assign sg_eip  = cur_q.sgeip;
endmodule

// File: rtl/vsip_compose_chk.sv
// Module: property checker bound to the composer top.
// Assumes: the same GEILEN as the instance it is bound to.
module vsip_compose_chk
    import vsip_pkg::*;
#(
    parameter int GEILEN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inj_seip,
    input logic              inj_stip,
    input logic              plat_seip,
    input logic [GEILEN:0]   ge_pend,
    input logic [GEILEN:0]   ge_en,
    input logic [SEL_W-1:0]  ge_sel,
    input logic [TIME_W-1:0] time_now,
    input logic [TIME_W-1:0] time_delta,
    input logic [TIME_W-1:0] time_cmp,
    input logic              vs_seip,
    input logic              vs_stip,
    input logic              sg_eip,
    input logic              sel_illegal
);
    AST_SEIP_INJ: assert property (@(posedge clk) disable iff (!rst_n)
        inj_seip |=> vs_seip); // R1
    AST_SEIP_PLAT: assert property (@(posedge clk) disable iff (!rst_n)
        plat_seip |=> vs_seip); // R1
    AST_STIP_INJ: assert property (@(posedge clk) disable iff (!rst_n)
        inj_stip |=> vs_stip); // R2
    AST_SGEIP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((ge_pend[GEILEN:1] & ge_en[GEILEN:1]) == '0) |=> !sg_eip); // R3
    AST_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ge_sel == '0 && !inj_seip && !plat_seip) |=> !vs_seip); // R5
    AST_SEL_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_illegal && !inj_seip && !plat_seip) |=> !vs_seip); // R6
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!vs_seip && !vs_stip && !sg_eip)); // R8
endmodule

bind vsip_compose vsip_compose_chk #(.GEILEN(GEILEN)) u_chk (.*);

// File: tb/test_vsip_compose.sv
module test_vsip_compose;
    localparam int G = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          inj_seip, inj_stip, plat_seip;
    logic [G:0]    ge_pend, ge_en;
    logic [5:0]    ge_sel;
    logic [63:0]   time_now, time_delta, time_cmp;
    logic          vs_seip, vs_stip, sg_eip, sel_illegal;
    int            checks = 0;
    int            failures = 0;

    always #2 clk = ~clk;

    vsip_compose #(.GEILEN(G)) i_vsip_compose (
        .clk(clk), .rst_n(rst_n), .inj_seip(inj_seip), .inj_stip(inj_stip),
        .plat_seip(plat_seip), .ge_pend(ge_pend), .ge_en(ge_en), .ge_sel(ge_sel),
        .time_now(time_now), .time_delta(time_delta), .time_cmp(time_cmp),
        .vs_seip(vs_seip), .vs_stip(vs_stip), .sg_eip(sg_eip),
        .sel_illegal(sel_illegal)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Quiet inputs: nothing pending, timer far from firing.
    task automatic quiet();
        inj_seip = 0; inj_stip = 0; plat_seip = 0;
        ge_pend = '0; ge_en = '0; ge_sel = '0;
        time_now = '0; time_delta = '0; time_cmp = '1;
    endtask

    // Let one rising edge pass, then sample away from it.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 0; inj_seip = 1; inj_stip = 1; ge_pend = '1; ge_en = '1;
        step();
        check("R8 seip in reset", vs_seip, 1'b0);
        check("R8 stip in reset", vs_stip, 1'b0);
        check("R8 sgeip in reset", sg_eip, 1'b0);
        @(negedge clk); quiet(); rst_n = 1; step();
    endtask

    task automatic t_seip_sources();
        @(negedge clk); quiet(); inj_seip = 1; step();
        check("R1 injected", vs_seip, 1'b1);
        @(negedge clk); quiet(); plat_seip = 1; step();
        check("R1 platform", vs_seip, 1'b1);
        @(negedge clk); quiet(); ge_sel = 6'd3; ge_pend[3] = 1; step();
        check("R1 selected entry 3", vs_seip, 1'b1);
        @(negedge clk); quiet(); ge_sel = 6'd3; ge_pend[4] = 1; step();
        check("R1 other entry", vs_seip, 1'b0);
        @(negedge clk); quiet(); ge_sel = 6'(G); ge_pend[G] = 1; step();
        check("R1 top entry", vs_seip, 1'b1);
        check("R6 flag low at GEILEN", sel_illegal, 1'b0);
    endtask

    task automatic t_selector_edges();
        @(negedge clk); quiet(); ge_sel = 6'd0; ge_pend = '1; step();
        check("R5 selector zero", vs_seip, 1'b0);
        check("R4 bit0 via selector", vs_seip, 1'b0);
        @(negedge clk); quiet(); ge_sel = 6'(G + 1); ge_pend = '1; #1;
        check("R6 flag combinational", sel_illegal, 1'b1);
        step();
        check("R6 no guest term", vs_seip, 1'b0);
        @(negedge clk); ge_sel = 6'd63; #1;
        check("R6 flag at 63", sel_illegal, 1'b1);
    endtask

    task automatic t_timer();
        @(negedge clk); quiet(); time_now = 64'd100; time_cmp = 64'd100; step();
        check("R2 equal fires", vs_stip, 1'b1);
        @(negedge clk); time_cmp = 64'd101; step();
        check("R2 one short", vs_stip, 1'b0);
        @(negedge clk); time_now = 64'hFFFF_FFFF_FFFF_FFF0; time_delta = 64'h20;
        time_cmp = 64'h11; step();
        check("R2 wrap below", vs_stip, 1'b0);
        @(negedge clk); time_cmp = 64'h10; step();
        check("R2 wrap equal", vs_stip, 1'b1);
        @(negedge clk); time_now = 64'h7FFF_FFFF_FFFF_FFFF; time_delta = 0;
        time_cmp = 64'h8000_0000_0000_0000; step();
        check("R2 unsigned below", vs_stip, 1'b0);
        @(negedge clk); time_delta = 64'd2; step();
        check("R2 unsigned above", vs_stip, 1'b1);
        @(negedge clk); quiet(); inj_stip = 1; step();
        check("R2 injected", vs_stip, 1'b1);
    endtask

    task automatic t_sgeip();
        @(negedge clk); quiet(); ge_pend[5] = 1; ge_en[5] = 1; step();
        check("R3 pair", sg_eip, 1'b1);
        @(negedge clk); quiet(); ge_pend[5] = 1; ge_en[6] = 1; step();
        check("R3 mismatch", sg_eip, 1'b0);
        @(negedge clk); quiet(); ge_pend[G] = 1; ge_en[G] = 1; step();
        check("R3 top pair", sg_eip, 1'b1);
        @(negedge clk); quiet(); ge_pend[0] = 1; ge_en[0] = 1; step();
        check("R4 bit0 sgeip", sg_eip, 1'b0);
        check("R4 bit0 seip", vs_seip, 1'b0);
    endtask

    task automatic t_latency();
        @(negedge clk); quiet(); step();
        @(negedge clk); plat_seip = 1; #1;
        check("R7 before edge", vs_seip, 1'b0);
        step();
        check("R7 after edge", vs_seip, 1'b1);
        @(negedge clk); plat_seip = 0; #1;
        check("R7 hold before edge", vs_seip, 1'b1);
        step();
        check("R7 clear after edge", vs_seip, 1'b0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        quiet(); rst_n = 0;
        repeat (2) @(posedge clk);
        t_reset();
        t_seip_sources();
        t_selector_edges();
        t_timer();
        t_sgeip();
        t_latency();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule